// File: doc/BRIEF.md
# Speed-Mode PHY Configuration Sequencer

This block brings the card-side PHY into the right state after the host switches bus timing. A single start pulse carries a timing-mode code, whether the attached card is an SDIO device, a board option that asks for the PHY bypass ("slow") path, and whether the card clock runs above the 52 MHz class. The block then walks a fixed sequence of register updates and ends by requesting PHY initialization.

The SDIO-mode bit is updated first, for every mode except legacy. Next comes the slow-mode decision. In legacy timing, or whenever slow mode is chosen, the sequence skips the remaining setup and jumps straight to the init request. On the full path the block does four things in order. It loads the pad impedance fields. It drops the card clock. It rewrites the function-control register with the DDR and asynchronous settings for the mode, then raises the card clock again. Finally it either loads the strobe-mode logic-timing constant or clears the data-strobe enable. While the sequence runs, a busy flag is held and further start pulses are ignored.

Mode codes (4 bits): 0 legacy, 1 SDR12, 2 SDR25, 3 SD high-speed, 4 MMC high-speed, 5 DDR50, 6 DDR52, 7 HS200, 8 SDR104, 9 HS400 (strobe-based). Any other code is treated like the SDR modes 7/8.

Top module: `speed_mode_phy_cfg`

## Requirements
- R1: After reset, phy_slow=0, phy_sdio=0, func_ctrl=0x00000010, pad_impedance=0, logic_timing=0, strobe_en=0, card_clk_en=1, busy=0 and init_req=0.
- R2: When clk_above_52m is 1 at start, phy_slow ends the sequence at 0 whatever the mode, SDIO flag or option.
- R3: In legacy mode (code 0) with a low clock, phy_slow takes slow_opt. phy_sdio, func_ctrl and pad_impedance keep their previous values. init_req rises 4 clock edges after the edge that samples start.
- R4: In modes 1 to 4 with a low clock, phy_slow = card_is_sdio OR slow_opt. When it is 1, the sequence bypasses the remaining setup, just as in R3, and func_ctrl is unchanged. Every other mode gives phy_slow=0.
- R5: For every mode except legacy, phy_sdio takes card_is_sdio.
- R6: On the full path, func_ctrl is updated as follows: DQ DDR enables are bits [15:8], command DDR is bit 16, DQ asynchronous is bit 4. HS400 gives 0x1FF00. DDR50/DDR52 give 0x1FF10. Every other mode gives 0x00010.
- R7: On the full path, card_clk_en is 0 for exactly two cycles, and func_ctrl changes only while card_clk_en is 0.
- R8: On the full path, HS400 loads logic_timing with 0x00AA8977 and sets strobe_en. Every other mode clears strobe_en and leaves logic_timing unchanged.
- R9: pad_impedance is loaded with pull-down [12:8]=0xF and pull-up [4:0]=0xF (0x0F0F) only on the full path, while card_clk_en is still 1.
- R10: busy rises on the edge that accepts start and falls on the edge that raises init_req. init_req is a one-cycle pulse, 9 edges after acceptance on the full path. A start while busy is ignored.
- R11: A start presented in the cycle where init_req is high is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a configuration sequence |
| mode_sel | input | 4 | Requested timing-mode code |
| card_is_sdio | input | 1 | Attached card is SDIO |
| slow_opt | input | 1 | Board option requesting PHY bypass |
| clk_above_52m | input | 1 | Card clock is above the 52 MHz class |
| busy | output | 1 | Sequence in progress |
| init_req | output | 1 | One-cycle PHY initialization request |
| card_clk_en | output | 1 | Card clock enable |
| phy_slow | output | 1 | PHY bypass (slow) mode bit |
| phy_sdio | output | 1 | PHY SDIO-mode bit |
| func_ctrl | output | 32 | Function-control register value |
| pad_impedance | output | 16 | Pad impedance register value |
| logic_timing | output | 32 | Logic-timing register value |
| strobe_en | output | 1 | Data-strobe enable |

## Verification
The two events that can fall in the same cycle are the closing init request (with busy dropping) and a new start pulse. The bench drives a fresh start exactly in the cycle where init_req is high. It then checks that busy is set one edge later and that the new mode's result and latency appear. A second directed case places a start in the middle of a running sequence, with different mode inputs. It checks that neither the latency nor the outcome of the running sequence changes.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
    typedef enum logic [3:0] {
        MD_LEGACY = 4'd0,
        MD_SDR12  = 4'd1,
        MD_SDR25  = 4'd2,
        MD_SD_HS  = 4'd3,
        MD_MMC_HS = 4'd4,
        MD_DDR50  = 4'd5,
        MD_DDR52  = 4'd6,
        MD_HS200  = 4'd7,
        MD_SDR104 = 4'd8,
        MD_HS400  = 4'd9
    } mode_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_SDIO, ST_SLOW, ST_PAD, ST_GATE,
        ST_FUNC, ST_UNGATE, ST_STROBE, ST_INIT
    } step_e;
endpackage

// File: rtl/pmc_mode_decode.sv
module pmc_mode_decode
    import pmc_pkg::*;
(
    input  logic [3:0] mode,
    input  logic       sdio,
    input  logic       opt,
    input  logic       high,
    output logic       slow,
    output logic       bypass,
    output logic       hs400,
    output logic       ddr
);
    always_comb begin
        slow = 1'b0;
        if (!high) begin
            unique case (mode)
                MD_LEGACY:                               slow = opt;
                MD_SDR12, MD_SDR25, MD_SD_HS, MD_MMC_HS: slow = sdio | opt;
                default:                                 slow = 1'b0;
            endcase
        end
        bypass = slow || (mode == MD_LEGACY);
        hs400  = (mode == MD_HS400);
        ddr    = (mode == MD_DDR50) || (mode == MD_DDR52);
    end
endmodule

// File: rtl/pmc_func_encode.sv
module pmc_func_encode #(
    parameter int REG_W     = 32,
    parameter int DQ_LANES  = 8,
    parameter int DQ_LSB    = 8,
    parameter int ASYNC_BIT = 4
) (
    input  logic [REG_W-1:0] prev,
    input  logic             hs400,
    input  logic             ddr,
    output logic [REG_W-1:0] next
);
    localparam int CMD_BIT = DQ_LSB + DQ_LANES;

    logic             ddr_any;
    logic [DQ_LANES-1:0] lane_ddr;

    assign ddr_any = hs400 | ddr;

    for (genvar i = 0; i < DQ_LANES; i++) begin : g_lane
        assign lane_ddr[i] = ddr_any;
    end

    always_comb begin
        next = prev;
        next[DQ_LSB +: DQ_LANES] = lane_ddr;
        next[CMD_BIT]            = ddr_any;
        next[ASYNC_BIT]          = !hs400;
    end
endmodule

// File: rtl/speed_mode_phy_cfg.sv
module speed_mode_phy_cfg
    import pmc_pkg::*;
#(
    parameter int          REG_W        = 32,
    parameter int          DQ_LANES     = 8,
    parameter int          DQ_LSB       = 8,
    parameter int          ASYNC_BIT    = 4,
    parameter int          IMP_W        = 5,
    parameter int          IMP_PD_LSB   = 8,
    parameter logic [4:0]  IMP_PD_DEF   = 5'hF,
    parameter logic [4:0]  IMP_PU_DEF   = 5'hF,
    parameter logic [31:0] STROBE_TIMING = 32'h00AA8977
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [3:0]       mode_sel,
    input  logic             card_is_sdio,
    input  logic             slow_opt,
    input  logic             clk_above_52m,
    output logic             busy,
    output logic             init_req,
    output logic             card_clk_en,
    output logic             phy_slow,
    output logic             phy_sdio,
    output logic [REG_W-1:0] func_ctrl,
    output logic [15:0]      pad_impedance,
    output logic [REG_W-1:0] logic_timing,
    output logic             strobe_en
);
    localparam logic [REG_W-1:0] FUNC_RST = REG_W'(1) << ASYNC_BIT;

    typedef struct packed {
        step_e            step;
        logic [3:0]       mode;
        logic             sdio_in;
        logic             opt;
        logic             high;
        logic             slow;
        logic             sdio_mode;
        logic [REG_W-1:0] func;
        logic [15:0]      pad;
        logic [REG_W-1:0] ltime;
        logic             strobe;
        logic             clk_en;
        logic             busy;
        logic             init;
    } regs_t;

    regs_t q_q, d_d;

    logic             dec_slow, dec_bypass, dec_hs400, dec_ddr;
    logic [REG_W-1:0] func_next;

    pmc_mode_decode u_dec (
        .mode   (q_q.mode),
        .sdio   (q_q.sdio_in),
        .opt    (q_q.opt),
        .high   (q_q.high),
        .slow   (dec_slow),
        .bypass (dec_bypass),
        .hs400  (dec_hs400),
        .ddr    (dec_ddr)
    );

    pmc_func_encode #(
        .REG_W     (REG_W),
        .DQ_LANES  (DQ_LANES),
        .DQ_LSB    (DQ_LSB),
        .ASYNC_BIT (ASYNC_BIT)
    ) u_enc (
        .prev  (q_q.func),
        .hs400 (dec_hs400),
        .ddr   (dec_ddr),
        .next  (func_next)
    );

    always_comb begin
        d_d      = q_q;
        d_d.init = 1'b0;
        unique case (q_q.step)
            ST_IDLE: if (start) begin
                d_d.step    = ST_SDIO;
                d_d.mode    = mode_sel;
                d_d.sdio_in = card_is_sdio;
                d_d.opt     = slow_opt;
                d_d.high    = clk_above_52m;
                d_d.busy    = 1'b1;
            end
            ST_SDIO: begin
                if (q_q.mode != MD_LEGACY) d_d.sdio_mode = q_q.sdio_in;
                d_d.step = ST_SLOW;
            end
            ST_SLOW: begin
                d_d.slow = dec_slow;
                d_d.step = dec_bypass ? ST_INIT : ST_PAD;
            end
            ST_PAD: begin
                d_d.pad = '0;
                d_d.pad[IMP_PD_LSB +: IMP_W] = IMP_PD_DEF;
                d_d.pad[0 +: IMP_W]          = IMP_PU_DEF;
                d_d.step = ST_GATE;
            end
            ST_GATE: begin
                d_d.clk_en = 1'b0;
                d_d.step   = ST_FUNC;
            end
            ST_FUNC: begin
                d_d.func = func_next;
                d_d.step = ST_UNGATE;
            end
            ST_UNGATE: begin
                d_d.clk_en = 1'b1;
                d_d.step   = ST_STROBE;
            end
            ST_STROBE: begin
                if (dec_hs400) begin
                    d_d.ltime  = STROBE_TIMING;
                    d_d.strobe = 1'b1;
                end else begin
                    d_d.strobe = 1'b0;
                end
                d_d.step = ST_INIT;
            end
            ST_INIT: begin
                d_d.init = 1'b1;
                d_d.busy = 1'b0;
                d_d.step = ST_IDLE;
            end
            default: d_d.step = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q        <= '0;
            q_q.step   <= ST_IDLE;
            q_q.func   <= FUNC_RST;
            q_q.clk_en <= 1'b1;
        end else begin
            q_q <= d_d;
        end
    end

    assign busy          = q_q.busy;
    assign init_req      = q_q.init;
    assign card_clk_en   = q_q.clk_en;
    assign phy_slow      = q_q.slow;
    assign phy_sdio      = q_q.sdio_mode;
    assign func_ctrl     = q_q.func;
    assign pad_impedance = q_q.pad;
    assign logic_timing  = q_q.ltime;
    assign strobe_en     = q_q.strobe;

    a_r2_no_slow_when_fast: assert property (@(posedge clk) disable iff (!rst_n)
        (q_q.step == ST_SLOW && q_q.high) |=> !q_q.slow);
    a_r7_func_under_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q_q.func) |-> !q_q.clk_en);
    a_r8_strobe_with_timing: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q_q.strobe) |-> (q_q.ltime == STROBE_TIMING));
    a_r9_pad_before_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q_q.pad) |-> (q_q.clk_en && q_q.busy));
    a_r10_init_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        q_q.init |=> !q_q.init);
    a_r10_init_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        q_q.init |-> !q_q.busy);
    a_r10_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q_q.busy) |-> $past(start));
    a_r6_cmd_tracks_dq: assert property (@(posedge clk) disable iff (!rst_n)
        q_q.func[DQ_LSB + DQ_LANES] == (&q_q.func[DQ_LSB +: DQ_LANES]));
endmodule

// File: tb/test_speed_mode_phy_cfg.sv
module test_speed_mode_phy_cfg;
    localparam time CLK_P = 20ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  mode_sel = '0;
    logic        card_is_sdio = 1'b0;
    logic        slow_opt = 1'b0;
    logic        clk_above_52m = 1'b0;
    logic        busy, init_req, card_clk_en, phy_slow, phy_sdio, strobe_en;
    logic [31:0] func_ctrl, logic_timing;
    logic [15:0] pad_impedance;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    speed_mode_phy_cfg i_speed_mode_phy_cfg (
        .clk, .rst_n, .start, .mode_sel, .card_is_sdio, .slow_opt,
        .clk_above_52m, .busy, .init_req, .card_clk_en, .phy_slow,
        .phy_sdio, .func_ctrl, .pad_impedance, .logic_timing, .strobe_en
    );

    // mode, sdio, opt, high | slow, sdio_mode, func, pad, ltime, strobe, latency
    typedef struct packed {
        logic [3:0]  mode;
        logic        sdio;
        logic        opt;
        logic        high;
        logic        e_slow;
        logic        e_sdio;
        logic [31:0] e_func;
        logic [15:0] e_pad;
        logic [31:0] e_lt;
        logic        e_strobe;
        logic [7:0]  e_lat;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{4'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 32'h00010, 16'h0000, 32'h0,        1'b0, 8'd4},
        '{4'd9, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h1FF00, 16'h0F0F, 32'h00AA8977, 1'b1, 8'd9},
        '{4'd6, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 32'h1FF10, 16'h0F0F, 32'h00AA8977, 1'b0, 8'd9},
        '{4'd3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 32'h1FF10, 16'h0F0F, 32'h00AA8977, 1'b0, 8'd4},
        '{4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h1FF10, 16'h0F0F, 32'h00AA8977, 1'b0, 8'd4},
        '{4'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h00010, 16'h0F0F, 32'h00AA8977, 1'b0, 8'd9},
        '{4'd4, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h00010, 16'h0F0F, 32'h00AA8977, 1'b0, 8'd9},
        '{4'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h00010, 16'h0F0F, 32'h00AA8977, 1'b0, 8'd4},
        '{4'd5, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h1FF10, 16'h0F0F, 32'h00AA8977, 1'b0, 8'd9},
        '{4'd1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 32'h1FF10, 16'h0F0F, 32'h00AA8977, 1'b0, 8'd4},
        '{4'd7, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 32'h00010, 16'h0F0F, 32'h00AA8977, 1'b0, 8'd9},
        '{4'd9, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 32'h1FF00, 16'h0F0F, 32'h00AA8977, 1'b1, 8'd9},
        '{4'd8, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h00010, 16'h0F0F, 32'h00AA8977, 1'b0, 8'd9}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // Drive start at a negedge; return at the negedge where init_req is seen.
    task automatic run(input logic [3:0] m, input logic s, input logic o, input logic h,
                       input int inject, output int lat, output int gate_cyc,
                       output logic busy1);
        mode_sel = m; card_is_sdio = s; slow_opt = o; clk_above_52m = h;
        start = 1'b1;
        lat = 0; gate_cyc = 0; busy1 = 1'b0;
        while (1) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (lat == 1) begin
                start = 1'b0;
                busy1 = busy;
            end
            if (lat == inject) begin
                start = 1'b1; mode_sel = 4'd0; slow_opt = 1'b1;
                card_is_sdio = 1'b1; clk_above_52m = 1'b0;
            end
            if (lat == inject + 1) start = 1'b0;
            if (!card_clk_en) gate_cyc++;
            if (init_req || lat > 40) break;
        end
    endtask

    initial begin
        #(CLK_P * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        int lat, gc;
        logic b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 slow", phy_slow, 0);
        chk("R1 sdio", phy_sdio, 0);
        chk("R1 func", func_ctrl, 32'h10);
        chk("R1 pad", pad_impedance, 0);
        chk("R1 ltime", logic_timing, 0);
        chk("R1 strobe", strobe_en, 0);
        chk("R1 clk_en", card_clk_en, 1);
        chk("R1 busy", busy, 0);
        chk("R1 init", init_req, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            run(VECS[i].mode, VECS[i].sdio, VECS[i].opt, VECS[i].high, -5, lat, gc, b1);
            chk("R10 latency", lat, VECS[i].e_lat);
            chk("R10 busy after start", b1, 1);
            chk("R10 busy low at init", busy, 0);
            chk("R2/R3/R4 slow", phy_slow, VECS[i].e_slow);
            chk("R3/R5 sdio", phy_sdio, VECS[i].e_sdio);
            chk("R6 func", func_ctrl, VECS[i].e_func);
            chk("R9 pad", pad_impedance, VECS[i].e_pad);
            chk("R8 ltime", logic_timing, VECS[i].e_lt);
            chk("R8 strobe", strobe_en, VECS[i].e_strobe);
            chk("R7 gated cycles", gc, (VECS[i].e_lat == 8'd9) ? 2 : 0);
            chk("R7 clk back on", card_clk_en, 1);
            @(negedge clk);
            chk("R10 init one cycle", init_req, 0);
        end

        // R10: start during busy ignored
        run(4'd9, 1'b0, 1'b0, 1'b1, 3, lat, gc, b1);
        chk("R10 ignored start latency", lat, 9);
        chk("R10 ignored start slow", phy_slow, 0);
        chk("R10 ignored start func", func_ctrl, 32'h1FF00);
        chk("R10 ignored start sdio", phy_sdio, 0);
        @(negedge clk);
        chk("R10 stays idle", busy, 0);

        // R11: start in the init_req cycle is accepted
        run(4'd6, 1'b0, 1'b0, 1'b1, -5, lat, gc, b1);
        chk("R11 init seen", init_req, 1);
        run(4'd1, 1'b1, 1'b0, 1'b0, -5, lat, gc, b1);
        chk("R11 busy after back-to-back start", b1, 1);
        chk("R11 latency", lat, 4);
        chk("R11 slow", phy_slow, 1);
        chk("R11 sdio", phy_sdio, 1);
        chk("R11 func kept", func_ctrl, 32'h1FF10);

        finish_run();
    end
endmodule